// File: doc/BRIEF.md
# Upward-Growing Stack Pointer Unit

This block keeps the byte-wide stack pointer of a small 8-bit processor core and turns stack commands into accesses to an external byte RAM. The stack grows toward higher addresses: the pointer always names the most recently filled slot. A byte push first advances the pointer and then writes at the new value. A byte pop reads at the current value and then steps the pointer back. After reset the pointer is 07h, so the first byte pushed goes to 08h. Software can also set the pointer to any value, for example to move the stack into a free region such as 30h–7Fh.

Subroutine linkage is handled in the block. A call command carries a 16-bit return address and stores it as two bytes in two consecutive cycles, low byte first. A return command reads the two bytes back, high byte first, and presents the rebuilt 16-bit address. All pointer arithmetic wraps modulo 256 and no error is flagged. The RAM must return read data in the same cycle as the address (asynchronous read). Writes take effect at the clock edge while the write enable is high.

Command strobes are accepted only in a cycle where `cmd_ready_o` is high. While a call or return is in its second cycle, `cmd_ready_o` is low and any strobe in that cycle is dropped, so the issuer must hold off or re-issue. The result outputs `pop_valid_o` and `ret_valid_o` are single-cycle qualifiers with no back-pressure, and the consumer must take the value in that cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer reads 07h, `cmd_ready_o` is high, and `ram_we_o`, `pop_valid_o` and `ret_valid_o` are low.
- R2: An accepted push drives `ram_we_o` high with `ram_addr_o` equal to the pointer plus one and `ram_wdata_o` equal to the pushed byte, all in the same cycle. The pointer then reads one higher from the next cycle on.
- R3: An accepted pop drives `ram_addr_o` with the current pointer and leaves `ram_we_o` low. In the next cycle `pop_valid_o` is high for one cycle with the byte read, and the pointer reads one lower.
- R4: Increment and decrement wrap modulo 256: a push at FFh writes address 00h and leaves the pointer at 00h, and a pop at 00h leaves it at FFh.
- R5: When push and pop are both requested in one cycle, only the push takes effect and no pop result appears.
- R6: An accepted load sets the pointer to `load_value_i` from the next cycle on, and performs no RAM write.
- R7: An accepted call writes the low byte of `call_addr_i` at pointer+1 in its first cycle. In the second cycle it writes the high byte at pointer+2 with `cmd_ready_o` low. The pointer ends two higher.
- R8: An accepted return reads the high byte at the pointer in its first cycle and the low byte at pointer−1 in its second cycle, with `cmd_ready_o` low. One cycle later `ret_valid_o` pulses with `ret_addr_o` = {high, low}. The pointer ends two lower.
- R9: Strobes presented while `cmd_ready_o` is low are ignored: they cause no write, no pointer change beyond the ongoing command, and no result.
- R10: When several strobes are presented at once, one is accepted by fixed priority: call, then return, then push, then pop, then load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push one byte |
| push_data_i | input | 8 | Byte to push |
| pop_i | input | 1 | Pop one byte |
| call_i | input | 1 | Save a return address (two cycles) |
| call_addr_i | input | 16 | Return address to save |
| ret_i | input | 1 | Restore a return address (two cycles) |
| load_i | input | 1 | Overwrite the pointer |
| load_value_i | input | 8 | New pointer value |
| cmd_ready_o | output | 1 | Strobes accepted this cycle |
| ram_addr_o | output | 8 | Stack RAM address |
| ram_we_o | output | 1 | Stack RAM write enable |
| ram_wdata_o | output | 8 | Stack RAM write data |
| ram_rdata_i | input | 8 | Stack RAM read data (same cycle) |
| pop_valid_o | output | 1 | Popped byte is valid this cycle |
| pop_data_o | output | 8 | Popped byte |
| ret_valid_o | output | 1 | Restored address is valid this cycle |
| ret_addr_o | output | 16 | Restored return address |
| sp_o | output | 8 | Current pointer value |

## Verification
A corrupted pointer shows at `sp_o` on the cycle after the faulty update. On the very next stack access it also shows at `ram_addr_o`, which is compared combinationally before the clock edge. A sequencer stuck in or skipping its second phase shows within one cycle as a wrong `cmd_ready_o`, a missing second write, or a missing or misplaced `ret_valid_o`. Wrong byte order or a wrong stored byte stays hidden until the matching pop or return, where the scoreboard compares the delivered value against the value originally pushed.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_PUSH, OP_POP, OP_CALL, OP_RET, OP_LOAD
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_CALL2, ST_RET2
  } seq_e;

  typedef enum logic [1:0] {
    MV_HOLD, MV_INC, MV_DEC, MV_LOAD
  } move_e;

  typedef enum logic [1:0] {
    RD_NONE, RD_POP, RD_HI, RD_LO
  } rd_e;
endpackage

// File: rtl/sp_cmd_arb.sv
module sp_cmd_arb
  import sp_pkg::*;
(
  input  logic ready_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic load_i,
  output op_e  op_o
);
  // fixed priority: call > return > push > pop > load
  always_comb begin
    op_o = OP_NONE;
    if (ready_i) begin
      if (call_i)      op_o = OP_CALL;
      else if (ret_i)  op_o = OP_RET;
      else if (push_i) op_o = OP_PUSH;
      else if (pop_i)  op_o = OP_POP;
      else if (load_i) op_o = OP_LOAD;
    end
  end
endmodule

// File: rtl/sp_ptr.sv
module sp_ptr
  import sp_pkg::*;
#(
  parameter int          PTR_W    = 8,
  parameter logic [PTR_W-1:0] RESET_SP = 8'h07
) (
  input  logic             clk,
  input  logic             rst_n,
  input  move_e            move_i,
  input  logic [PTR_W-1:0] load_i,
  output logic [PTR_W-1:0] sp_o,
  output logic [PTR_W-1:0] sp_inc_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] sp_q;

  assign sp_inc_o = sp_q + ONE;   // wraps modulo 2**PTR_W
  assign sp_o     = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= RESET_SP;
    end else begin
      case (move_i)
        MV_INC:  sp_q <= sp_inc_o;
        MV_DEC:  sp_q <= sp_q - ONE;
        MV_LOAD: sp_q <= load_i;
        default: sp_q <= sp_q;
      endcase
    end
  end
endmodule

// File: rtl/sp_seq.sv
module sp_seq
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RA_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic [RA_W-1:0]   call_addr_i,
  output logic              ready_o,
  output move_e             move_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output rd_e               rd_o
);
  seq_e              st_q, st_d;
  logic [DATA_W-1:0] hi_q;

  assign ready_o = (st_q == ST_IDLE);

  always_comb begin
    st_d    = st_q;
    move_o  = MV_HOLD;
    we_o    = 1'b0;
    wdata_o = push_data_i;
    rd_o    = RD_NONE;
    case (st_q)
      ST_IDLE: begin
        case (op_i)
          OP_PUSH: begin
            move_o = MV_INC;
            we_o   = 1'b1;
          end
          OP_POP: begin
            move_o = MV_DEC;
            rd_o   = RD_POP;
          end
          OP_CALL: begin
            move_o  = MV_INC;
            we_o    = 1'b1;
            wdata_o = call_addr_i[DATA_W-1:0];
            st_d    = ST_CALL2;
          end
          OP_RET: begin
            move_o = MV_DEC;
            rd_o   = RD_HI;
            st_d   = ST_RET2;
          end
          OP_LOAD: move_o = MV_LOAD;
          default: ;
        endcase
      end
      ST_CALL2: begin
        move_o  = MV_INC;
        we_o    = 1'b1;
        wdata_o = hi_q;
        st_d    = ST_IDLE;
      end
      ST_RET2: begin
        move_o = MV_DEC;
        rd_o   = RD_LO;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      hi_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && op_i == OP_CALL)
        hi_q <= call_addr_i[RA_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/sp_readback.sv
module sp_readback
  import sp_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RA_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rd_e               rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              ret_valid_o,
  output logic [RA_W-1:0]   ret_addr_o
);
  logic [DATA_W-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pop_valid_o <= 1'b0;
      pop_data_o  <= '0;
      ret_valid_o <= 1'b0;
      ret_addr_o  <= '0;
      hi_q        <= '0;
    end else begin
      pop_valid_o <= (rd_i == RD_POP);
      ret_valid_o <= (rd_i == RD_LO);
      if (rd_i == RD_POP) pop_data_o <= rdata_i;
      if (rd_i == RD_HI)  hi_q       <= rdata_i;
      if (rd_i == RD_LO)  ret_addr_o <= {hi_q, rdata_i};
    end
  end
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int               PTR_W    = 8,
  parameter int               DATA_W   = 8,
  parameter logic [PTR_W-1:0] RESET_SP = 8'h07,
  localparam int              RA_W     = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic              call_i,
  input  logic [RA_W-1:0]   call_addr_i,
  input  logic              ret_i,
  input  logic              load_i,
  input  logic [PTR_W-1:0]  load_value_i,
  output logic              cmd_ready_o,
  output logic [PTR_W-1:0]  ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic              pop_valid_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              ret_valid_o,
  output logic [RA_W-1:0]   ret_addr_o,
  output logic [PTR_W-1:0]  sp_o
);
  op_e              op;
  move_e            move;
  rd_e              rd;
  logic [PTR_W-1:0] sp_inc;

  sp_cmd_arb u_arb (
    .ready_i (cmd_ready_o),
    .push_i  (push_i),
    .pop_i   (pop_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .load_i  (load_i),
    .op_o    (op)
  );

  sp_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .push_data_i (push_data_i),
    .call_addr_i (call_addr_i),
    .ready_o     (cmd_ready_o),
    .move_o      (move),
    .we_o        (ram_we_o),
    .wdata_o     (ram_wdata_o),
    .rd_o        (rd)
  );

  sp_ptr #(.PTR_W(PTR_W), .RESET_SP(RESET_SP)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .move_i   (move),
    .load_i   (load_value_i),
    .sp_o     (sp_o),
    .sp_inc_o (sp_inc)
  );

  // pre-increment on writes, current slot on reads
  assign ram_addr_o = (move == MV_INC) ? sp_inc : sp_o;

  sp_readback #(.DATA_W(DATA_W)) u_rb (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_i        (rd),
    .rdata_i     (ram_rdata_i),
    .pop_valid_o (pop_valid_o),
    .pop_data_o  (pop_data_o),
    .ret_valid_o (ret_valid_o),
    .ret_addr_o  (ret_addr_o)
  );
endmodule

// File: rtl/stack_ptr_unit_chk.sv
module stack_ptr_unit_chk #(
  parameter int PTR_W  = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_i,
  input logic              pop_i,
  input logic              call_i,
  input logic              ret_i,
  input logic              load_i,
  input logic [PTR_W-1:0]  load_value_i,
  input logic              cmd_ready_o,
  input logic [PTR_W-1:0]  ram_addr_o,
  input logic              ram_we_o,
  input logic              pop_valid_o,
  input logic              ret_valid_o,
  input logic [PTR_W-1:0]  sp_o
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic take_push, take_pop, take_load, take_call, take_ret;
  assign take_call = cmd_ready_o && call_i;
  assign take_ret  = cmd_ready_o && ret_i && !call_i;
  assign take_push = cmd_ready_o && push_i && !call_i && !ret_i;
  assign take_pop  = cmd_ready_o && pop_i && !push_i && !call_i && !ret_i;
  assign take_load = cmd_ready_o && load_i && !pop_i && !push_i && !call_i && !ret_i;

  AST_WRITE_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we_o |-> ram_addr_o == sp_o + ONE) else $error("write address"); // R2

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_push |=> sp_o == $past(sp_o) + ONE) else $error("push step"); // R2

  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_pop |=> pop_valid_o && sp_o == $past(sp_o) - ONE) else $error("pop step"); // R3

  AST_BOTH_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready_o && push_i && pop_i && !call_i && !ret_i) |=> !pop_valid_o) else $error("push/pop"); // R5

  AST_LOAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take_load |-> !ram_we_o) else $error("load write"); // R6

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    take_load |=> sp_o == $past(load_value_i)) else $error("load value"); // R6

  AST_CALL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    take_call |=> !cmd_ready_o && ram_we_o) else $error("call phase"); // R7

  AST_RET_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    take_ret |=> !cmd_ready_o ##1 ret_valid_o) else $error("ret phase"); // R8

  AST_RESULTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pop_valid_o, ret_valid_o})) else $error("results"); // R3
endmodule

bind stack_ptr_unit stack_ptr_unit_chk #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .push_i       (push_i),
  .pop_i        (pop_i),
  .call_i       (call_i),
  .ret_i        (ret_i),
  .load_i       (load_i),
  .load_value_i (load_value_i),
  .cmd_ready_o  (cmd_ready_o),
  .ram_addr_o   (ram_addr_o),
  .ram_we_o     (ram_we_o),
  .pop_valid_o  (pop_valid_o),
  .ret_valid_o  (ret_valid_o),
  .sp_o         (sp_o)
);

// File: tb/stack_ptr_unit_bench.sv
module stack_ptr_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, pop_i = 0, call_i = 0, ret_i = 0, load_i = 0;
  logic [7:0]  push_data_i = 0, load_value_i = 0;
  logic [15:0] call_addr_i = 0;
  logic        cmd_ready_o, ram_we_o, pop_valid_o, ret_valid_o;
  logic [7:0]  ram_addr_o, ram_wdata_o, ram_rdata_i, pop_data_o, sp_o;
  logic [15:0] ret_addr_o;

  int nchk = 0;
  int nbad = 0;
  logic [7:0]  exp_sp;
  logic [7:0]  mem [256];
  logic [7:0]  pop_q [$];
  logic [15:0] ret_q [$];

  always #4 clk = ~clk;

  stack_ptr_unit u_stack_ptr_unit (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .call_i(call_i), .call_addr_i(call_addr_i), .ret_i(ret_i),
    .load_i(load_i), .load_value_i(load_value_i), .cmd_ready_o(cmd_ready_o),
    .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
    .ram_rdata_i(ram_rdata_i), .pop_valid_o(pop_valid_o), .pop_data_o(pop_data_o),
    .ret_valid_o(ret_valid_o), .ret_addr_o(ret_addr_o), .sp_o(sp_o)
  );

  // stack RAM model: asynchronous read, write at the edge
  assign ram_rdata_i = mem[ram_addr_o];
  always @(posedge clk) if (ram_we_o) mem[ram_addr_o] <= ram_wdata_o;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: every result pulse must match the scoreboard head
  always @(negedge clk) begin
    if (rst_n && pop_valid_o) begin
      if (pop_q.size() == 0) check("R3", "unexpected pop result", 1, 0);
      else check("R3", "popped byte", {24'd0, pop_data_o}, {24'd0, pop_q.pop_front()});
    end
    if (rst_n && ret_valid_o) begin
      if (ret_q.size() == 0) check("R8", "unexpected return result", 1, 0);
      else check("R8", "return address", {16'd0, ret_addr_o}, {16'd0, ret_q.pop_front()});
    end
  end

  task automatic do_push(input logic [7:0] d);
    push_i = 1; push_data_i = d;
    #1;
    check("R2", "push we", {31'd0, ram_we_o}, 1);
    check("R2", "push addr", {24'd0, ram_addr_o}, {24'd0, exp_sp + 8'd1});
    check("R2", "push wdata", {24'd0, ram_wdata_o}, {24'd0, d});
    @(negedge clk);
    push_i = 0;
    exp_sp = exp_sp + 8'd1;
    check("R2", "sp after push", {24'd0, sp_o}, {24'd0, exp_sp});
  endtask

  task automatic do_pop(input logic [7:0] expd);
    pop_i = 1;
    pop_q.push_back(expd);
    #1;
    check("R3", "pop addr", {24'd0, ram_addr_o}, {24'd0, exp_sp});
    check("R3", "pop no write", {31'd0, ram_we_o}, 0);
    @(negedge clk);
    pop_i = 0;
    exp_sp = exp_sp - 8'd1;
    check("R3", "sp after pop", {24'd0, sp_o}, {24'd0, exp_sp});
  endtask

  task automatic do_load(input logic [7:0] v);
    load_i = 1; load_value_i = v;
    #1;
    check("R6", "load no write", {31'd0, ram_we_o}, 0);
    @(negedge clk);
    load_i = 0;
    exp_sp = v;
    check("R6", "sp after load", {24'd0, sp_o}, {24'd0, v});
  endtask

  // call while other strobes are held during the busy cycle (R9)
  task automatic do_call(input logic [15:0] a);
    call_i = 1; call_addr_i = a;
    #1;
    check("R7", "call lo addr", {24'd0, ram_addr_o}, {24'd0, exp_sp + 8'd1});
    check("R7", "call lo data", {24'd0, ram_wdata_o}, {24'd0, a[7:0]});
    @(negedge clk);
    call_i = 0; push_i = 1; pop_i = 1; load_i = 1; ret_i = 1;
    push_data_i = 8'hEE; load_value_i = 8'h99;
    #1;
    check("R7", "busy in second call cycle", {31'd0, cmd_ready_o}, 0);
    check("R7", "call hi addr", {24'd0, ram_addr_o}, {24'd0, exp_sp + 8'd2});
    check("R7", "call hi data", {24'd0, ram_wdata_o}, {24'd0, a[15:8]});
    @(negedge clk);
    push_i = 0; pop_i = 0; load_i = 0; ret_i = 0;
    exp_sp = exp_sp + 8'd2;
    check("R9", "sp after call with ignored strobes", {24'd0, sp_o}, {24'd0, exp_sp});
    check("R7", "stored lo", {24'd0, mem[exp_sp - 8'd1]}, {24'd0, a[7:0]});
    check("R7", "stored hi", {24'd0, mem[exp_sp]}, {24'd0, a[15:8]});
    check("R9", "ready back", {31'd0, cmd_ready_o}, 1);
  endtask

  task automatic do_ret(input logic [15:0] expa);
    ret_i = 1;
    ret_q.push_back(expa);
    #1;
    check("R8", "ret hi addr", {24'd0, ram_addr_o}, {24'd0, exp_sp});
    @(negedge clk);
    ret_i = 0; pop_i = 1; push_i = 1; push_data_i = 8'hDD;
    #1;
    check("R8", "busy in second ret cycle", {31'd0, cmd_ready_o}, 0);
    check("R8", "ret lo addr", {24'd0, ram_addr_o}, {24'd0, exp_sp - 8'd1});
    check("R9", "no write while busy", {31'd0, ram_we_o}, 0);
    @(negedge clk);
    pop_i = 0; push_i = 0;
    exp_sp = exp_sp - 8'd2;
    check("R8", "sp after ret", {24'd0, sp_o}, {24'd0, exp_sp});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("WD", "watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_sp = 8'h07;
    // R1 reset state
    check("R1", "reset sp", {24'd0, sp_o}, 32'h07);
    check("R1", "reset ready", {31'd0, cmd_ready_o}, 1);
    check("R1", "reset we", {31'd0, ram_we_o}, 0);
    check("R1", "reset valids", {30'd0, pop_valid_o, ret_valid_o}, 0);

    // R2/R3 basic LIFO: first push lands at 08h
    do_push(8'hA1);
    check("R2", "first slot 08h", {24'd0, mem[8'h08]}, 32'hA1);
    do_push(8'hB2);
    do_push(8'hC3);
    do_pop(8'hC3);
    do_pop(8'hB2);
    do_pop(8'hA1);

    // R5 push and pop together: push only
    push_i = 1; pop_i = 1; push_data_i = 8'h6E;
    #1;
    check("R5", "write taken", {31'd0, ram_we_o}, 1);
    @(negedge clk);
    push_i = 0; pop_i = 0;
    exp_sp = exp_sp + 8'd1;
    check("R5", "sp after push+pop", {24'd0, sp_o}, {24'd0, exp_sp});
    @(negedge clk);
    check("R5", "byte stored", {24'd0, mem[exp_sp]}, 32'h6E);

    // R6 load moves stack to scratch area
    do_load(8'h30);

    // R7/R8/R9 call and return
    do_call(16'h1234);
    do_push(8'h55);
    do_pop(8'h55);
    do_ret(16'h1234);

    // R10 priority: call over push and load
    call_i = 1; push_i = 1; load_i = 1; call_addr_i = 16'hBEEF; load_value_i = 8'h77;
    #1;
    check("R10", "call wins lo data", {24'd0, ram_wdata_o}, 32'hEF);
    @(negedge clk);
    call_i = 0; push_i = 0; load_i = 0;
    @(negedge clk);
    exp_sp = exp_sp + 8'd2;
    check("R10", "sp after call priority", {24'd0, sp_o}, {24'd0, exp_sp});
    // return over pop
    ret_i = 1; pop_i = 1;
    ret_q.push_back(16'hBEEF);
    @(negedge clk);
    ret_i = 0; pop_i = 0;
    @(negedge clk);
    exp_sp = exp_sp - 8'd2;
    check("R10", "sp after ret priority", {24'd0, sp_o}, {24'd0, exp_sp});
    // pop over load
    pop_i = 1; load_i = 1; load_value_i = 8'hC0;
    pop_q.push_back(mem[exp_sp]);
    @(negedge clk);
    pop_i = 0; load_i = 0;
    exp_sp = exp_sp - 8'd1;
    check("R10", "pop wins over load", {24'd0, sp_o}, {24'd0, exp_sp});

    // R4 wrap around
    do_load(8'hFF);
    do_push(8'h5A);
    check("R4", "wrap to 00h", {24'd0, sp_o}, 32'h00);
    check("R4", "stored at 00h", {24'd0, mem[8'h00]}, 32'h5A);
    do_pop(8'h5A);
    check("R4", "wrap to FFh", {24'd0, sp_o}, 32'hFF);

    repeat (3) @(negedge clk);
    check("R3", "pop results all seen", pop_q.size(), 0);
    check("R8", "return results all seen", ret_q.size(), 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule